// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup

This block resolves a destination address to a next hop by longest prefix match, without any search. The upper address bits index a first-level table directly, so every short prefix owns a fixed set of slots. Each first-level entry holds a flag and a payload. With the flag set, the payload is the final next hop. With the flag clear, the payload names a block in a second-level table, and the low address bits pick the slot inside that block. Longer prefixes are stored there. A lookup therefore costs at most two table reads, whatever the table contents.

Lookups enter on a valid/ready request stream and leave on a valid/ready response stream. The pipeline accepts one request per cycle and always answers after a fixed latency of two cycles. When a route needs only the first level, the second read still happens but its result is ignored. A response that the consumer does not take stalls the whole pipeline: `req_ready` falls, and every stage holds its state until `rsp_ready` returns. A plain write port loads either table one entry per cycle. Route computation and the order in which the tables are filled belong to the software that drives this port.

Default sizing is a 16-bit address, an 8-bit first-level index, an 8-bit offset, 8-bit next hops and 8 extension blocks.

Top module: `lpm_direct_lookup`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Until it is written, every first-level slot reports no route (hop 0, hit 0), and a later reset restores this.
- R2: A request accepted in a cycle (`req_valid` and `req_ready` high at a rising edge) produces its response two rising edges later. If the first-level entry has the flag (data bit NH_W) set, `rsp_hop` is its low NH_W bits.
- R3: If the flag is clear, the low PTR_W payload bits select an extension block. `rsp_hop` is the extension entry at index {block, low OFF_W address bits}.
- R4: Next hop 0 means no route. When the selected hop is 0, from either level, `rsp_hit` is 0 and `rsp_hop` is 0. Otherwise `rsp_hit` is 1.
- R5: With `rsp_ready` held high, requests on consecutive cycles are each answered, in order, on consecutive cycles.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_hop` and `rsp_hit` hold steady. No accepted request is lost or reordered.
- R7: Without back-pressure, a lookup accepted in the same cycle as a write to the entry it uses returns the old contents. A lookup accepted in the next cycle returns the new contents. This holds for both levels.
- R8: A write with `wr_sel`=0 stores `wr_data` (flag at bit NH_W, payload below it) into first-level slot `wr_addr[L1_BITS-1:0]`. A write with `wr_sel`=1 stores `wr_data[NH_W-1:0]` into extension slot `wr_addr[L2_IDX_W-1:0]` ({block, offset}). Once written, a first-level slot remains loaded until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Pipeline can accept a request |
| req_addr | input | ADDR_W | Destination address to resolve |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hop | output | NH_W | Resolved next hop, 0 when no route |
| rsp_hit | output | 1 | A route was found |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 selects the first level, 1 the extension table |
| wr_addr | input | WA_W | Slot index for the write |
| wr_data | input | NH_W+1 | Entry to store (flag in the top bit for the first level) |

## Verification
The bench examines the read-versus-write collision on each level in turn. A design that commits the extension write one cycle too early hands the same-cycle lookup the new hop. A design that delays it too long gives the following lookup the stale one. It also pairs a short-prefix slot, a pointer slot and a first-level entry written empty against addresses at the offset edges 0x00 and 0xFF. A wrong block/offset concatenation, or a hop-0 entry counted as a hit, shows up there as a wrong hop or a stray hit. A multi-cycle stall with two lookups in flight exposes a pipeline that drops, duplicates or reorders responses when `rsp_ready` returns.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic {
    TGT_L1 = 1'b0,
    TGT_L2 = 1'b1
  } wr_target_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpm_l1_table.sv
module lpm_l1_table #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ENT_W = 9,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data,
  output logic             rd_live,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] live;

  // storage array: no reset, read-before-write on a shared edge
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  // per-slot loaded flags, cleared only by reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live    <= '0;
      rd_live <= 1'b0;
    end else begin
      if (wr_en) live[wr_idx] <= 1'b1;
      if (rd_en) rd_live <= live[rd_idx];
    end
  end

  // R8: a loaded slot never reverts to unloaded outside reset
  assert_live_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~live & $past(live)) == '0));

endmodule

// File: rtl/lpm_l2_table.sv
module lpm_l2_table #(
  parameter int unsigned IDX_W = 11,
  parameter int unsigned NH_W  = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NH_W-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [NH_W-1:0]  wr_data
);

  logic [NH_W-1:0]  mem [DEPTH];
  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic [NH_W-1:0]  pend_data;

  // writes land one cycle late so they line up with the second pipeline stage
  always_ff @(posedge clk) begin
    if (!rst_n) pend_v <= 1'b0;
    else        pend_v <= wr_en;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pend_idx  <= wr_idx;
      pend_data <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_v) mem[pend_idx] <= pend_data;
    if (rd_en)  rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/lpm_direct_lookup.sv
module lpm_direct_lookup
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned L1_BITS   = 8,
  parameter int unsigned NH_W      = 8,
  parameter int unsigned L2_BLOCKS = 8,
  localparam int unsigned OFF_W    = ADDR_W - L1_BITS,
  localparam int unsigned PTR_W    = (L2_BLOCKS > 1) ? $clog2(L2_BLOCKS) : 1,
  localparam int unsigned L2_IDX_W = PTR_W + OFF_W,
  localparam int unsigned WA_W     = imax(L1_BITS, L2_IDX_W),
  localparam int unsigned ENT_W    = NH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NH_W-1:0]   rsp_hop,
  output logic              rsp_hit,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [ENT_W-1:0]  wr_data
);

  logic adv;
  assign adv       = !rsp_valid || rsp_ready;
  assign req_ready = adv;

  wr_target_e tgt;
  assign tgt = wr_target_e'(wr_sel);

  // ---- stage 1: first-level read ----
  logic [ENT_W-1:0] l1_ent;
  logic             l1_live;
  logic             s1_valid;
  logic [OFF_W-1:0] s1_off;

  lpm_l1_table #(.IDX_W(L1_BITS), .ENT_W(ENT_W)) u_l1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (adv),
    .rd_idx  (req_addr[ADDR_W-1 -: L1_BITS]),
    .rd_data (l1_ent),
    .rd_live (l1_live),
    .wr_en   (wr_en && tgt == TGT_L1),
    .wr_idx  (wr_addr[L1_BITS-1:0]),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_off   <= '0;
    end else if (adv) begin
      s1_valid <= req_valid;
      s1_off   <= req_addr[OFF_W-1:0];
    end
  end

  // ---- stage 2: extension read, first-level result carried alongside ----
  logic [NH_W-1:0] l2_hop;
  logic            s2_valid;
  logic            s2_live;
  logic            s2_final;
  logic [NH_W-1:0] s2_pay;

  lpm_l2_table #(.IDX_W(L2_IDX_W), .NH_W(NH_W)) u_l2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (adv),
    .rd_idx  ({l1_ent[PTR_W-1:0], s1_off}),
    .rd_data (l2_hop),
    .wr_en   (wr_en && tgt == TGT_L2),
    .wr_idx  (wr_addr[L2_IDX_W-1:0]),
    .wr_data (wr_data[NH_W-1:0])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_live  <= 1'b0;
      s2_final <= 1'b0;
      s2_pay   <= '0;
    end else if (adv) begin
      s2_valid <= s1_valid;
      s2_live  <= l1_live;
      s2_final <= l1_ent[NH_W];
      s2_pay   <= l1_ent[NH_W-1:0];
    end
  end

  // ---- result select: extension bypassed for final first-level entries ----
  logic [NH_W-1:0] hop_sel;
  always_comb begin
    if (!s2_live)      hop_sel = '0;
    else if (s2_final) hop_sel = s2_pay;
    else               hop_sel = l2_hop;
  end

  assign rsp_valid = s2_valid;
  assign rsp_hop   = hop_sel;
  assign rsp_hit   = (hop_sel != '0);

  // R2: an advancing first stage always yields a response next cycle
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && adv) |=> rsp_valid);

  // R6: a refused response stays put
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hop) && $stable(rsp_hit)));

  // R5: a taken response with nothing behind it leaves the output empty
  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !s1_valid) |=> !rsp_valid);

  // R1: an unloaded first-level slot never reports a route
  assert_unloaded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !s2_live) |-> !rsp_hit);

endmodule

// File: tb/lpm_direct_lookup_test.sv
module lpm_direct_lookup_test;

  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [7:0]  rsp_hop;
  logic        rsp_hit;
  logic        wr_en;
  logic        wr_sel;
  logic [10:0] wr_addr;
  logic [8:0]  wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lpm_direct_lookup uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hop(rsp_hop), .rsp_hit(rsp_hit),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // {address, expected hit, expected hop}
  localparam logic [24:0] VEC [NV] = '{
    {16'h1200, 1'b1, 8'h05},   // R2 final entry, low offset
    {16'h12FF, 1'b1, 8'h05},   // R2 final entry, high offset
    {16'h3410, 1'b1, 8'h21},   // R3 block 2
    {16'h34FF, 1'b1, 8'h22},   // R3 top offset
    {16'h3400, 1'b1, 8'h23},   // R3 bottom offset
    {16'h3411, 1'b0, 8'h00},   // R4 empty extension slot
    {16'h5601, 1'b0, 8'h00},   // R4 first-level written empty
    {16'h7880, 1'b1, 8'h44},   // R3 block 5
    {16'h7881, 1'b0, 8'h00},   // R4 empty in block 5
    {16'h9999, 1'b0, 8'h00}    // R1 never loaded
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [10:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
    wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 req_ready after reset", 32'(req_ready), 32'd1);

    // R8 table load
    wr(1'b0, 11'h012, {1'b1, 8'h05});
    wr(1'b0, 11'h034, {1'b0, 8'h02});
    wr(1'b0, 11'h056, {1'b1, 8'h00});
    wr(1'b0, 11'h078, {1'b0, 8'h05});
    for (int k = 0; k < 256; k++) wr(1'b1, {3'd2, 8'(k)}, 9'h000);
    for (int k = 0; k < 256; k++) wr(1'b1, {3'd5, 8'(k)}, 9'h000);
    wr(1'b1, {3'd2, 8'h10}, 9'h021);
    wr(1'b1, {3'd2, 8'hFF}, 9'h022);
    wr(1'b1, {3'd2, 8'h00}, 9'h023);
    wr(1'b1, {3'd5, 8'h80}, 9'h044);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);

    // R5 back-to-back vector walk
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk($sformatf("R5 valid vec%0d", i - 2), 32'(rsp_valid), 32'd1);
        chk($sformatf("R4 hit vec%0d", i - 2), 32'(rsp_hit), 32'(VEC[i-2][8]));
        chk($sformatf("R3 hop vec%0d", i - 2), 32'(rsp_hop), 32'(VEC[i-2][7:0]));
      end
      if (i < NV) begin
        req_valid = 1'b1; req_addr = VEC[i][24:9];
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R5 drained", 32'(rsp_valid), 32'd0);

    // R6 back-pressure with two lookups in flight
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 16'h1200;
    @(negedge clk);
    req_addr = 16'h3410;
    @(negedge clk);
    req_valid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      chk("R6 stalled valid", 32'(rsp_valid), 32'd1);
      chk("R6 stalled hop", 32'(rsp_hop), 32'h05);
      chk("R6 req_ready low", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    chk("R6 first after release", 32'(rsp_hop), 32'h05);
    @(negedge clk);
    chk("R6 second valid", 32'(rsp_valid), 32'd1);
    chk("R6 second hop", 32'(rsp_hop), 32'h21);
    @(negedge clk);
    chk("R6 no duplicate", 32'(rsp_valid), 32'd0);

    // R7 first-level collision
    wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 11'h012; wr_data = {1'b1, 8'h09};
    req_valid = 1'b1; req_addr = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 L1 same-cycle old", 32'(rsp_hop), 32'h05);
    @(negedge clk);
    chk("R7 L1 next-cycle new", 32'(rsp_hop), 32'h09);

    // R7 extension collision
    wr_en = 1'b1; wr_sel = 1'b1; wr_addr = {3'd2, 8'h10}; wr_data = 9'h031;
    req_valid = 1'b1; req_addr = 16'h3410;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 L2 same-cycle old", 32'(rsp_hop), 32'h21);
    @(negedge clk);
    chk("R7 L2 next-cycle new", 32'(rsp_hop), 32'h31);
    @(negedge clk);

    // R1 reset unloads the first level
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_addr = 16'h1200;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 valid after re-reset", 32'(rsp_valid), 32'd1);
    chk("R1 hit after re-reset", 32'(rsp_hit), 32'd0);
    chk("R1 hop after re-reset", 32'(rsp_hop), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule